// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master from the system clock. It decides how long SCL is held low and how long it is released. It tells the byte engine where each phase starts, and it marks the point within the low phase after which SDA may change. The START/STOP and bit sequencing live elsewhere. The byte engine raises `run` while it wants clock pulses and follows the strobes.

Two timing modes exist:

- **Standard mode.** A single 9-bit divider N, supplied as a 7-bit low field and a 2-bit high field, gives a symmetric clock. Each phase lasts 2N clocks, so one SCL period is nominally 4N system clocks.
- **Fast mode.** Separate half-counts for the low and high phases are doubled internally. A hold field sets how long after the falling edge the SDA-change strobe fires.

The high-phase count begins only once the synchronized SCL pin is seen high, so a target that stretches the clock lengthens the period instead of being overrun. Timing inputs are captured at phase boundaries only.

Software can also force SCL and SDA low for bus recovery. These manual level writes take effect only while a separate level write-enable is held. The synchronized pin levels are reported back.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_drive_low` and `sda_force_low` are 0, and `fall_stb`, `rise_stb` and `hold_stb` are 0 until `run` is raised.
- R2: With `fast_mode`=0, the divider is N = {`div_hi`,`div_lo`} (`div_hi` forms bits 8:7). The low phase (`scl_drive_low`=1) lasts 2N clocks. The high count is 2N clocks, so with no stretching SCL stays released for 2N+3 clocks.
- R3: A standard divider of 0 acts as 1. In fast mode, a low or high half-count of 0 also acts as 1.
- R4: With `fast_mode`=1, the low phase lasts 2·`lo_half` clocks and SCL stays released for 2·`hi_half`+3 clocks.
- R5: `hold_stb` pulses once per low phase, D clocks after the `fall_stb` cycle. In standard mode D = N. In fast mode D = min(`hold_cnt`, low length − 1).
- R6: The high count starts only after `scl_level` is 1. `rise_stb` fires in the first counted high cycle, which is 3 clocks after release when SCL is not held low. Each clock of external stretching delays `rise_stb` and extends the released time by that clock.
- R7: The low length and hold delay are captured when the low phase begins, and the high length when the high phase begins. A change in the middle of a phase affects only later phases.
- R8: When `run` is 0 at the end of a high phase, the generator stops with SCL released and emits no further strobes. A period already under way is completed.
- R9: `scl_level` and `sda_level` follow `scl_in` and `sda_in` through a two-stage synchronizer, two clocks late. Both read 1 after reset.
- R10: A pulse on `lvl_wr` loads `lvl_scl_d`/`lvl_sda_d` into the manual levels only when `lvl_we`=1, and is otherwise ignored. A manual level of 0 forces `scl_drive_low` (combined by OR with the generator) or `sda_force_low` to 1.
- R11: `fall_stb` marks the first cycle of each low phase and never coincides with `rise_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Byte engine requests SCL pulses |
| fast_mode | input | 1 | 1 selects separate low/high half-counts and hold field |
| div_lo | input | 7 | Standard divider, bits 6:0 |
| div_hi | input | 2 | Standard divider, bits 8:7 |
| lo_half | input | 8 | Fast mode low phase half-count |
| hi_half | input | 8 | Fast mode high phase half-count |
| hold_cnt | input | 8 | Fast mode SDA hold delay in clocks |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| lvl_we | input | 1 | Write-enable for manual levels |
| lvl_wr | input | 1 | Manual level write strobe |
| lvl_scl_d | input | 1 | Manual SCL level to load (0 forces low) |
| lvl_sda_d | input | 1 | Manual SDA level to load (0 forces low) |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_force_low | output | 1 | Manual pull of SDA low |
| scl_level | output | 1 | Synchronized SCL level |
| sda_level | output | 1 | Synchronized SDA level |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First counted cycle of a high phase |
| hold_stb | output | 1 | SDA may change from this cycle |

## Verification
The bench builds the block with its default widths: a 7+2-bit divider, 8-bit half-counts and a two-stage synchronizer. These put a divider of 130 within reach, so the high divider field is exercised. The pin model lets the bench stretch SCL for a chosen number of clocks, which exposes the wait for a high level before the high count starts. A divider change issued exactly at a falling strobe shows whether timing is captured at the phase boundary. The hold clamp and the zero-as-one cases are covered by fast-mode rows with out-of-range fields.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int DIVLO_W = 7,
  parameter int DIVHI_W = 2,
  parameter int HALF_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               fast_mode,
  input  logic [DIVLO_W-1:0] div_lo,
  input  logic [DIVHI_W-1:0] div_hi,
  input  logic [HALF_W-1:0]  lo_half,
  input  logic [HALF_W-1:0]  hi_half,
  input  logic [HALF_W-1:0]  hold_cnt,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               lvl_we,
  input  logic               lvl_wr,
  input  logic               lvl_scl_d,
  input  logic               lvl_sda_d,
  output logic               scl_drive_low,
  output logic               sda_force_low,
  output logic               scl_level,
  output logic               sda_level,
  output logic               fall_stb,
  output logic               rise_stb,
  output logic               hold_stb
);
  localparam int DIV_W = DIVLO_W + DIVHI_W;
  localparam int CW = ((DIV_W > HALF_W) ? DIV_W : HALF_W) + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} ph_t;

  ph_t st;
  logic [CW-1:0] e, lo_q, hi_q, hold_q;
  logic [SYNC_N-1:0] scl_sr, sda_sr;
  logic man_scl, man_sda;

  logic [DIV_W-1:0]  div_n, div_eff;
  logic [HALF_W-1:0] lo_f, hi_f;
  logic [CW-1:0]     std_len, lo_len, hi_len, hold_fast, hold_len;

  assign div_n     = {div_hi, div_lo};
  assign div_eff   = (div_n == '0) ? DIV_W'(1) : div_n;
  assign lo_f      = (lo_half == '0) ? HALF_W'(1) : lo_half;
  assign hi_f      = (hi_half == '0) ? HALF_W'(1) : hi_half;
  assign std_len   = CW'({div_eff, 1'b0});
  assign lo_len    = fast_mode ? CW'({lo_f, 1'b0}) : std_len;
  assign hi_len    = fast_mode ? CW'({hi_f, 1'b0}) : std_len;
  assign hold_fast = (CW'(hold_cnt) > lo_len - ONE) ? lo_len - ONE : CW'(hold_cnt);
  assign hold_len  = fast_mode ? hold_fast : CW'(div_eff);

  assign scl_level = scl_sr[SYNC_N-1];
  assign sda_level = sda_sr[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_N-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_N-2:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_scl <= 1'b1;
      man_sda <= 1'b1;
    end else if (lvl_we && lvl_wr) begin
      man_scl <= lvl_scl_d;
      man_sda <= lvl_sda_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      e      <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      hold_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (run) begin
          st     <= S_LOW;
          e      <= '0;
          lo_q   <= lo_len;
          hold_q <= hold_len;
        end
        S_LOW: if (e == lo_q - ONE) begin
          st <= S_WAIT;
          e  <= '0;
        end else begin
          e <= e + ONE;
        end
        S_WAIT: if (scl_level) begin
          st   <= S_HIGH;
          e    <= '0;
          hi_q <= hi_len;
        end
        S_HIGH: if (e == hi_q - ONE) begin
          e <= '0;
          if (run) begin
            st     <= S_LOW;
            lo_q   <= lo_len;
            hold_q <= hold_len;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          e <= e + ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (st == S_LOW) | ~man_scl;
  assign sda_force_low = ~man_sda;
  assign fall_stb      = (st == S_LOW)  && (e == '0);
  assign rise_stb      = (st == S_HIGH) && (e == '0);
  assign hold_stb      = (st == S_LOW)  && (e == hold_q);
endmodule

module i2c_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic fall_stb,
  input logic rise_stb,
  input logic hold_stb,
  input logic scl_drive_low,
  input logic sda_force_low,
  input logic scl_level,
  input logic lvl_we,
  input logic lvl_wr
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb}));
  // R11
  fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_drive_low);
  // R5
  hold_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stb |-> scl_drive_low);
  // R6
  rise_seen_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(scl_level));
  // R10
  sda_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lvl_we && lvl_wr) |=> $stable(sda_force_low));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (.*);

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, fast_mode = 1'b0;
  logic [6:0] div_lo = '0;
  logic [1:0] div_hi = '0;
  logic [7:0] lo_half = '0, hi_half = '0, hold_cnt = '0;
  logic lvl_we = 1'b0, lvl_wr = 1'b0, lvl_scl_d = 1'b1, lvl_sda_d = 1'b1;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_force_low, scl_level, sda_level;
  logic fall_stb, rise_stb, hold_stb;
  int stretch_left = 0;
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign scl_in = ~scl_drive_low & (stretch_left == 0);
  assign sda_in = ~sda_force_low;

  always @(negedge clk)
    if (!scl_drive_low && stretch_left > 0) stretch_left <= stretch_left - 1;

  i2c_scl_timer u0 (.*);

  // fast, divider, lo_half, hi_half, hold, exp low, exp released, exp hold offset
  localparam int TV [6][8] = '{
    '{0,   3,  0,  0, 0,   6,   9,   3},
    '{0,   0,  0,  0, 0,   2,   5,   1},
    '{0, 130,  0,  0, 0, 260, 263, 130},
    '{1,   0, 16, 11, 7,  32,  25,   7},
    '{1,   0,  2,  0, 9,   4,   5,   3},
    '{1,   0,  0,  5, 0,   2,  13,   0}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!fall_stb);
  endtask

  task automatic count_period(output int lo_n, output int rel_n,
                              output int hold_i, output int rise_i);
    lo_n = 0; rel_n = 0; hold_i = -1; rise_i = -1;
    while (scl_drive_low) begin
      if (hold_stb && hold_i < 0) hold_i = lo_n;
      lo_n++;
      @(negedge clk);
    end
    while (!scl_drive_low) begin
      if (rise_stb && rise_i < 0) rise_i = rel_n;
      rel_n++;
      @(negedge clk);
    end
  endtask

  task automatic set_std(int n);
    fast_mode = 1'b0;
    div_lo = 7'(n);
    div_hi = 2'(n >> 7);
  endtask

  task automatic lvl_write(bit we, bit s, bit d);
    lvl_we = we; lvl_scl_d = s; lvl_sda_d = d; lvl_wr = 1'b1;
    @(negedge clk);
    lvl_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      finish_run();
    end
  end

  initial begin
    int lo_n, rel_n, hold_i, rise_i, falls, lows, rises;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_drive_low", scl_drive_low, 0);
    chk("R1 sda_force_low", sda_force_low, 0);
    chk("R1 strobes", {fall_stb, rise_stb, hold_stb}, 0);
    // R9 levels high after reset
    chk("R9 scl_level reset", scl_level, 1);
    chk("R9 sda_level reset", sda_level, 1);

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      fast_mode = TV[i][0][0];
      div_lo = 7'(TV[i][1]);
      div_hi = 2'(TV[i][1] >> 7);
      lo_half = 8'(TV[i][2]);
      hi_half = 8'(TV[i][3]);
      hold_cnt = 8'(TV[i][4]);
      run = 1'b1;
      wait_fall();
      wait_fall();
      count_period(lo_n, rel_n, hold_i, rise_i);
      chk($sformatf("R2 R3 R4 low row%0d", i), lo_n, TV[i][5]);
      chk($sformatf("R2 R3 R4 released row%0d", i), rel_n, TV[i][6]);
      chk($sformatf("R5 hold row%0d", i), hold_i, TV[i][7]);
      chk($sformatf("R6 rise row%0d", i), rise_i, 3);
    end

    // R7 change at a falling strobe
    set_std(3);
    wait_fall();
    wait_fall();
    set_std(5);
    count_period(lo_n, rel_n, hold_i, rise_i);
    chk("R7 low keeps old", lo_n, 6);
    chk("R7 hold keeps old", hold_i, 3);
    chk("R7 high takes new", rel_n, 13);
    count_period(lo_n, rel_n, hold_i, rise_i);
    chk("R7 next low new", lo_n, 10);
    chk("R7 next hold new", hold_i, 5);

    // R6 clock stretching by 10 clocks
    set_std(3);
    wait_fall();
    wait_fall();
    stretch_left = 11;
    count_period(lo_n, rel_n, hold_i, rise_i);
    chk("R6 stretched released", rel_n, 19);
    chk("R6 stretched rise", rise_i, 13);

    // R8 stop after current period
    wait_fall();
    run = 1'b0;
    rises = 0;
    repeat (40) begin
      if (rise_stb) rises++;
      @(negedge clk);
    end
    chk("R8 period completed", rises, 1);
    falls = 0; lows = 0;
    repeat (30) begin
      if (fall_stb || rise_stb || hold_stb) falls++;
      if (scl_drive_low) lows++;
      @(negedge clk);
    end
    chk("R8 no strobes idle", falls, 0);
    chk("R8 released idle", lows, 0);

    // R10 manual levels, R9 synchronizer
    lvl_write(1'b0, 1'b0, 1'b0);
    chk("R10 ignored scl", scl_drive_low, 0);
    chk("R10 ignored sda", sda_force_low, 0);
    lvl_write(1'b1, 1'b0, 1'b0);
    chk("R10 forced scl", scl_drive_low, 1);
    chk("R10 forced sda", sda_force_low, 1);
    @(negedge clk);
    chk("R9 scl_level latency", scl_level, 1);
    @(negedge clk);
    chk("R9 scl_level low", scl_level, 0);
    chk("R9 sda_level low", sda_level, 0);
    lvl_write(1'b0, 1'b1, 1'b1);
    chk("R10 guarded release ignored", scl_drive_low, 1);
    lvl_write(1'b1, 1'b1, 1'b1);
    chk("R10 released scl", scl_drive_low, 0);
    chk("R10 released sda", sda_force_low, 0);
    lvl_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 scl_level back high", scl_level, 1);

    finish_run();
  end
endmodule